// File: doc/BRIEF.md
# Dual-Latch DAC Write Sequencer

This block lets a host store 8-bit codes into either of two converter data latches that sit behind one shared parallel port. The host raises a one-cycle request carrying a channel bit and a data byte. The sequencer then runs the device-side strobes in a fixed order. It drives chip select low, presents the channel bit and the data, waits out the setup interval, and holds the write strobe low for the pulse-width interval. It then raises write, and raises chip select one cycle later.

Every interval is a number of clock cycles fixed at elaboration. Each count is the nanosecond minimum divided by the clock period and rounded up, with a floor of one cycle. A supply parameter chooses between the slower minimums for the low supply and the faster minimums for the high supply. The latches on the far side are transparent while both strobes are low. Each latch keeps the byte that was on the bus when the first strobe went high. Because of this, the bus contents are frozen for the whole time chip select is low.

Top module: `dac_wr_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dac_cs_n` and `dac_wr_n` are 1 and `req_busy` and `req_done` are 0.
- R2: A request sampled in idle makes `dac_cs_n` go to 0 in the next cycle. In that same cycle `dac_sel` equals `req_chan` (0 selects latch A, 1 selects latch B) and `dac_data` equals `req_data`.
- R3: `dac_cs_n` and `dac_sel` are in place for at least the setup count of cycles before `dac_wr_n` falls. `dac_wr_n` is never 0 while `dac_cs_n` is 1.
- R4: `dac_wr_n` stays 0 for exactly the pulse count of consecutive cycles. `dac_data` is stable for at least the data-setup count of cycles before `dac_wr_n` rises.
- R5: `dac_cs_n` rises exactly one cycle after `dac_wr_n` rises. `dac_sel` and `dac_data` do not change while `dac_cs_n` is 0.
- R6: `req_busy` is 1 from the cycle after acceptance through the last cycle with `dac_cs_n` at 0. `req_done` is 1 for exactly one cycle, the cycle in which `dac_cs_n` returns to 1.
- R7: A request raised while `req_busy` is 1 is ignored. It causes no extra write strobe and changes neither latch.
- R8: Each count is the nanosecond minimum divided by the clock period, rounded up, and at least 1. The default low-supply settings with a 4 ns clock give a setup of 23 cycles and a pulse of 23 cycles. The data minimum of 20 cycles is covered by setup plus pulse.
- R9: A write with channel 0 changes only latch A, and a write with channel 1 changes only latch B. The selected latch ends up holding the requested byte.
- R10: Two requests issued back to back to opposite channels update both latches. The second request may be accepted in the cycle in which `req_done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request, sampled when idle |
| req_chan | input | 1 | Target latch: 0 = A, 1 = B |
| req_data | input | DATA_W | Byte to store |
| req_busy | output | 1 | Sequence in progress |
| req_done | output | 1 | One-cycle completion pulse |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_wr_n | output | 1 | Active-low write strobe |
| dac_sel | output | 1 | Latch select line |
| dac_data | output | DATA_W | Shared data bus |

## Verification
A wrong state or a wrong counter value inside the sequencer shows up directly at the strobe pins. It appears as a write edge that comes too early or too late, a pulse that is the wrong length, or a chip-select release that is not exactly one cycle after write rises. Each of these is visible within the transaction in which it occurs. A wrong captured byte or channel bit reaches the shared bus in the first cycle after acceptance. A latch model on the bench then stores it in the wrong place, or stores the wrong value, when write rises. That error is detected at that edge. An acceptance while busy would show up as an extra strobe for which no write was expected.

// File: rtl/dws_pkg.sv
package dws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD
    } dws_state_e;

    // Rounded-up cycle count for a nanosecond minimum, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Setup must satisfy strobe and select leads; data lead is shared with the pulse.
    function automatic int unsigned setup_cyc(input int unsigned cs_c, input int unsigned sel_c,
                                              input int unsigned dat_c, input int unsigned pw_c);
        int unsigned dat_rest;
        dat_rest = (dat_c > pw_c) ? dat_c - pw_c : 1;
        return max2(max2(cs_c, sel_c), max2(dat_rest, 1));
    endfunction

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return max2(1, $clog2(max_val));
    endfunction

endpackage

// File: rtl/dws_delay_cnt.sv
module dws_delay_cnt #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_s;

    cnt_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.cnt = load_val;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign expired = (r_q.cnt == '0);

endmodule

// File: rtl/dws_bus_hold.sv
module dws_bus_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              req_chan,
    input  logic [DATA_W-1:0] req_data,
    input  logic              cs_n,
    output logic              chan_sel,
    output logic [DATA_W-1:0] bus_data
);

    typedef struct packed {
        logic              sel;
        logic [DATA_W-1:0] data;
    } bus_s;

    bus_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (capture) begin
            r_d.sel  = req_chan;
            r_d.data = req_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign chan_sel = r_q.sel;
    assign bus_data = r_q.data;

    AST_BUS_FROZEN_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> ($stable(bus_data) && $stable(chan_sel))); // R5

endmodule

// File: rtl/dws_fsm.sv
module dws_fsm
    import dws_pkg::*;
#(
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned SETUP_CYC = 23,
    parameter int unsigned PULSE_CYC = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             cnt_expired,
    output logic             accept,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cs_n,
    output logic             wr_n,
    output logic             busy,
    output logic             done
);

    localparam logic [CNT_W-1:0] SETUP_M1 = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_M1 = CNT_W'(PULSE_CYC - 1);

    typedef struct packed {
        dws_state_e state;
        logic       cs_n;
        logic       wr_n;
        logic       busy;
        logic       done;
    } seq_s;

    seq_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accept   = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept    = 1'b1;
                    cnt_load  = 1'b1;
                    cnt_val   = SETUP_M1;
                    s_d.state = ST_SETUP;
                    s_d.cs_n  = 1'b0;
                    s_d.busy  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (cnt_expired) begin
                    cnt_load  = 1'b1;
                    cnt_val   = PULSE_M1;
                    s_d.state = ST_PULSE;
                    s_d.wr_n  = 1'b0;
                end
            end
            ST_PULSE: begin
                if (cnt_expired) begin
                    s_d.state = ST_HOLD;
                    s_d.wr_n  = 1'b1;
                end
            end
            ST_HOLD: begin
                s_d.state = ST_IDLE;
                s_d.cs_n  = 1'b1;
                s_d.busy  = 1'b0;
                s_d.done  = 1'b1;
            end
            default: begin
                s_d.state = ST_IDLE;
                s_d.cs_n  = 1'b1;
                s_d.wr_n  = 1'b1;
                s_d.busy  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state <= ST_IDLE;
            s_q.cs_n  <= 1'b1;
            s_q.wr_n  <= 1'b1;
            s_q.busy  <= 1'b0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_n = s_q.cs_n;
    assign wr_n = s_q.wr_n;
    assign busy = s_q.busy;
    assign done = s_q.done;

    AST_WR_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !cs_n); // R3
    AST_CS_RELEASE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |=> $rose(cs_n)); // R5
    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(!busy)); // R7

endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
    import dws_pkg::*;
#(
    parameter int unsigned DATA_W         = 8,
    parameter int unsigned CLK_PERIOD_PS  = 4000,
    parameter int unsigned HIGH_SUPPLY    = 0,
    parameter int unsigned LO_CS_SU_NS    = 90,
    parameter int unsigned HI_CS_SU_NS    = 60,
    parameter int unsigned LO_SEL_SU_NS   = 90,
    parameter int unsigned HI_SEL_SU_NS   = 60,
    parameter int unsigned LO_DATA_SU_NS  = 80,
    parameter int unsigned HI_DATA_SU_NS  = 30,
    parameter int unsigned LO_WR_PW_NS    = 90,
    parameter int unsigned HI_WR_PW_NS    = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_chan,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_busy,
    output logic              req_done,
    output logic              dac_cs_n,
    output logic              dac_wr_n,
    output logic              dac_sel,
    output logic [DATA_W-1:0] dac_data
);

    localparam bit          FAST      = (HIGH_SUPPLY != 0);
    localparam int unsigned CS_CYC    = ns_to_cyc(FAST ? HI_CS_SU_NS   : LO_CS_SU_NS,   CLK_PERIOD_PS);
    localparam int unsigned SEL_CYC   = ns_to_cyc(FAST ? HI_SEL_SU_NS  : LO_SEL_SU_NS,  CLK_PERIOD_PS);
    localparam int unsigned DATA_CYC  = ns_to_cyc(FAST ? HI_DATA_SU_NS : LO_DATA_SU_NS, CLK_PERIOD_PS);
    localparam int unsigned PULSE_CYC = ns_to_cyc(FAST ? HI_WR_PW_NS   : LO_WR_PW_NS,   CLK_PERIOD_PS);
    localparam int unsigned SETUP_CYC = setup_cyc(CS_CYC, SEL_CYC, DATA_CYC, PULSE_CYC);
    localparam int unsigned CNT_W     = cnt_width(max2(SETUP_CYC, PULSE_CYC));
    localparam int unsigned CHK_W     = CNT_W + 1;

    logic             accept;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_expired;
    logic             cs_n_w;
    logic             wr_n_w;

    dws_fsm #(
        .CNT_W     (CNT_W),
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .cnt_expired (cnt_expired),
        .accept      (accept),
        .cnt_load    (cnt_load),
        .cnt_val     (cnt_val),
        .cs_n        (cs_n_w),
        .wr_n        (wr_n_w),
        .busy        (req_busy),
        .done        (req_done)
    );

    dws_delay_cnt #(
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_expired)
    );

    dws_bus_hold #(
        .DATA_W (DATA_W)
    ) i_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept),
        .req_chan (req_chan),
        .req_data (req_data),
        .cs_n     (cs_n_w),
        .chan_sel (dac_sel),
        .bus_data (dac_data)
    );

    assign dac_cs_n = cs_n_w;
    assign dac_wr_n = wr_n_w;

    // Window counters for the timing checks on the strobe pins.
    localparam logic [CHK_W-1:0] SETUP_L = CHK_W'(SETUP_CYC);
    localparam logic [CHK_W-1:0] PULSE_L = CHK_W'(PULSE_CYC);

    logic [CHK_W-1:0] lead_q;
    logic [CHK_W-1:0] wlow_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q <= '0;
            wlow_q <= '0;
        end else begin
            if (cs_n_w)      lead_q <= '0;
            else if (wr_n_w) lead_q <= lead_q + 1'b1;
            if (wr_n_w)      wlow_q <= '0;
            else             wlow_q <= wlow_q + 1'b1;
        end
    end

    AST_SETUP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_wr_n) |-> (lead_q >= SETUP_L)); // R3
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_wr_n) |-> (wlow_q == PULSE_L)); // R4

endmodule

// File: tb/test_dac_wr_seq.sv
`timescale 1ns/1ps
module test_dac_wr_seq;

    localparam int unsigned PERIOD_PS = 4000;
    localparam int unsigned S_EXP     = (90 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int unsigned P_EXP     = (90 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int unsigned D_EXP     = (80 * 1000 + PERIOD_PS - 1) / PERIOD_PS;

    typedef struct {
        logic       chan;
        logic [7:0] data;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_chan = 1'b0;
    logic [7:0] req_data = '0;
    logic       req_busy, req_done, dac_cs_n, dac_wr_n, dac_sel;
    logic [7:0] dac_data;

    int checks = 0;
    int fails  = 0;
    item_t exp_q[$];
    logic [7:0] lat [2];
    logic [7:0] snap [2];

    always #2 clk = ~clk;

    dac_wr_seq i_dac_wr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_chan  (req_chan),
        .req_data  (req_data),
        .req_busy  (req_busy),
        .req_done  (req_done),
        .dac_cs_n  (dac_cs_n),
        .dac_wr_n  (dac_wr_n),
        .dac_sel   (dac_sel),
        .dac_data  (dac_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic send(input logic chan, input logic [7:0] data);
        item_t it;
        while (req_busy) @(negedge clk);
        it.chan = chan;
        it.data = data;
        exp_q.push_back(it);
        req_valid = 1'b1;
        req_chan  = chan;
        req_data  = data;
        @(negedge clk);
        req_valid = 1'b0;
        chk(dac_cs_n == 1'b0, "R2 cs_n low after accept", int'(dac_cs_n), 0);
        chk(dac_sel == chan, "R2 select", int'(dac_sel), int'(chan));
        chk(dac_data == data, "R2 data", int'(dac_data), int'(data));
        chk(req_busy == 1'b1, "R6 busy after accept", int'(req_busy), 1);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (req_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: latch model plus scoreboard
    logic       p_cs = 1'b1, p_wr = 1'b1, p_sel = 1'b0;
    logic [7:0] p_db = '0;
    int  lead = 0, wlow = 0, stable = 0, post = 0;
    bit  moved = 1'b0, busy_ok = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!dac_cs_n && p_cs) begin
                snap[0] = lat[0];
                snap[1] = lat[1];
                moved   = 1'b0;
                busy_ok = 1'b1;
                stable  = 0;
            end
            if (!dac_cs_n) begin
                if (!p_cs && (dac_data != p_db || dac_sel != p_sel)) begin
                    moved  = 1'b1;
                    stable = 1;
                end else begin
                    stable++;
                end
                if (!req_busy) busy_ok = 1'b0;
            end
            if (!dac_cs_n && dac_wr_n) lead++;
            if (dac_cs_n) lead = 0;
            if (!dac_wr_n) wlow++;

            if (p_wr && !dac_wr_n) begin
                chk(lead >= int'(S_EXP), "R3 setup lead", lead, int'(S_EXP));
                chk(lead == int'(S_EXP), "R8 setup count", lead, int'(S_EXP));
            end
            if (!p_wr && dac_wr_n) begin
                chk(wlow == int'(P_EXP), "R4 pulse width", wlow, int'(P_EXP));
                chk(stable - 1 >= int'(D_EXP), "R4 data setup", stable - 1, int'(D_EXP));
                wlow = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected write strobe", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(p_sel == it.chan, "R9 channel", int'(p_sel), int'(it.chan));
                    chk(lat[int'(p_sel)] == it.data, "R9 stored byte",
                        int'(lat[int'(p_sel)]), int'(it.data));
                    chk(lat[int'(!p_sel)] == snap[int'(!p_sel)], "R9 other latch held",
                        int'(lat[int'(!p_sel)]), int'(snap[int'(!p_sel)]));
                end
                post = 1;
            end else if (post == 1) begin
                chk(dac_cs_n == 1'b1, "R5 cs release one cycle after wr", int'(dac_cs_n), 1);
                chk(req_done == 1'b1, "R6 done pulse", int'(req_done), 1);
                chk(!moved, "R5 bus frozen under cs", int'(moved), 0);
                chk(busy_ok, "R6 busy during cs low", int'(busy_ok), 1);
                post = 2;
            end else if (post == 2) begin
                chk(req_done == 1'b0, "R6 done single cycle", int'(req_done), 0);
                post = 0;
            end

            // transparent latch model
            if (!dac_cs_n && !dac_wr_n) lat[int'(dac_sel)] = dac_data;
            p_cs  = dac_cs_n;
            p_wr  = dac_wr_n;
            p_sel = dac_sel;
            p_db  = dac_data;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] held_b;
        lat[0] = 8'h00;
        lat[1] = 8'h00;
        repeat (3) @(negedge clk);
        chk(dac_cs_n && dac_wr_n, "R1 strobes idle in reset", int'({dac_cs_n, dac_wr_n}), 3);
        chk(!req_busy && !req_done, "R1 flags low in reset", int'({req_busy, req_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dac_cs_n && dac_wr_n, "R1 strobes idle after reset", int'({dac_cs_n, dac_wr_n}), 3);
        chk(!req_busy && !req_done, "R1 flags low after reset", int'({req_busy, req_done}), 0);

        send(1'b0, 8'hA5); wait_idle();
        send(1'b1, 8'h5A); wait_idle();
        send(1'b0, 8'h00); wait_idle();
        send(1'b1, 8'hFF); wait_idle();

        // R7: requests while busy are dropped
        send(1'b0, 8'h3C);
        held_b = lat[1];
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_chan = 1'b1; req_data = 8'h81;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (60) @(negedge clk);
        chk(dac_cs_n == 1'b1, "R7 no extra cycle", int'(dac_cs_n), 1);
        chk(lat[1] == held_b, "R7 latch B untouched", int'(lat[1]), int'(held_b));
        chk(lat[0] == 8'h3C, "R7 latch A has real write", int'(lat[0]), 8'h3C);

        // R10: back-to-back writes to both channels
        send(1'b0, 8'h11);
        send(1'b1, 8'h22);
        wait_idle();
        chk(lat[0] == 8'h11, "R10 latch A", int'(lat[0]), 8'h11);
        chk(lat[1] == 8'h22, "R10 latch B", int'(lat[1]), 8'h22);
        chk(exp_q.size() == 0, "R7 no pending or extra writes", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule